// File: doc/BRIEF.md
# SDRAM Open-Row Command Sequencer

This block keeps a record of the row left open in every SDRAM bank and turns each incoming access into the shortest legal command stream. An access whose row matches the bank's open row gets a single column command (read or write). Any other access first closes the bank, then opens the requested row, then issues the column command. Rows are never closed after an access. A bank is closed only when a later access to the same bank needs a different row.

One row register and one valid bit are kept per bank. The valid bits are cleared by reset. An access to a bank whose valid bit is clear is handled as a miss, and its sequence still starts with a precharge, which an idle bank ignores. A configuration input selects between devices with four banks and devices with two. In two-bank mode the upper half of the bank indices is illegal. Such a request is reported as an error and produces no command.

Requests use a valid/ready handshake, and commands leave one per cycle behind a command strobe. A status strobe reports hit, miss or error once for every accepted request. SDRAM timing, refresh, device initialization and data transfer are handled elsewhere.

Top module: `sdram_page_tracker`

## Requirements
- R1: After reset, `req_ready` is 1, and `cmd_valid` and `stat_valid` are 0. Every bank is marked closed.
- R2: A page hit produces exactly one command, in the cycle after acceptance. The command is READ (code 3) or WRITE (code 4), carries the request's bank, and is followed by no precharge or activate.
- R3: A page miss produces PRECHARGE (code 1), ACTIVATE (code 2) and then READ or WRITE, on three consecutive cycles starting the cycle after acceptance. All three carry the request's bank, and ACTIVATE carries the request's row on `cmd_row`.
- R4: On a miss, the bank's row register takes the new row when ACTIVATE is issued. A later request to the same bank and row is a hit.
- R5: A row stays open after its access. Accesses to other banks, and rejected requests, leave it untouched.
- R6: A request to a bank whose valid bit is clear, such as the first access after reset, is a miss and its sequence starts with PRECHARGE.
- R7: With `cfg_four_bank` = 0, a request to bank 2 or 3 is accepted and flagged with `stat_err` = 1. It emits no command, and `req_ready` stays 1.
- R8: `req_ready` is 0 in exactly the two cycles that show PRECHARGE and ACTIVATE of a miss sequence. It is 1 again in the cycle that shows the final column command.
- R9: `stat_valid` is 1 for exactly one cycle, the cycle after each accepted request. `stat_hit` = 1 marks a hit, and `stat_hit` = 0 with `stat_err` = 0 marks a miss.
- R10: The final column command is WRITE when `req_write` was 1 and READ otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_four_bank | input | 1 | 1 selects four-bank devices, 0 selects two-bank devices |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_bank | input | BANK_W | Bank addressed by the request |
| req_row | input | ROW_W | Row addressed by the request |
| req_write | input | 1 | 1 for a write access, 0 for a read access |
| cmd_valid | output | 1 | Command strobe |
| cmd_code | output | 3 | Command: 1 precharge, 2 activate, 3 read, 4 write |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_row | output | ROW_W | Row of the command (meaningful on activate) |
| stat_valid | output | 1 | One-cycle status strobe per accepted request |
| stat_hit | output | 1 | Request was a page hit |
| stat_err | output | 1 | Request addressed a bank absent in two-bank mode |

## Verification
The bench goes after four corner cases:
- **Returning to an old row.** A bank is revisited with the row it held two accesses earlier. A tracker that compared against a stale row, or loaded the row at the wrong moment, would report a hit there.
- **Crossing the mode switch.** Banks 2 and 3 are addressed in two-bank mode, then reused in four-bank mode. A design that issued commands for rejected requests, or let them disturb the row registers, would lose its hits afterwards.
- **Row values at the edges.** The all-ones row and the zero row are both used.
- **Hits back to back, and reset.** The bench checks that consecutive hits stream out one command per cycle. It also checks that a second reset forces the next access to miss even when the row matches.

// File: rtl/sdram_pt_pkg.sv
package sdram_pt_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_PRE = 3'd1,
    CMD_ACT = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_RW   = 2'd2
  } seq_state_e;

endpackage

// File: rtl/sdram_pt_bank_regs.sv
module sdram_pt_bank_regs #(
  parameter int NBANK  = 4,
  parameter int ROW_W  = 12,
  parameter int BANK_W = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] lk_bank,
  input  logic [ROW_W-1:0]  lk_row,
  output logic              lk_hit,
  input  logic              ld_en,
  input  logic [BANK_W-1:0] ld_bank,
  input  logic [ROW_W-1:0]  ld_row
);

  logic [ROW_W-1:0] page_mem [NBANK];
  logic [NBANK-1:0] open_q;

  // row storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (ld_en) page_mem[ld_bank] <= ld_row;
  end

  always_ff @(posedge clk) begin
    if (rst)        open_q <= '0;
    else if (ld_en) open_q[ld_bank] <= 1'b1;
  end

  assign lk_hit = open_q[lk_bank] && (page_mem[lk_bank] == lk_row);

  // R4: a bank just loaded reads back as open
  assert_loaded_open_R4: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> open_q[$past(ld_bank)]);

endmodule

// File: rtl/sdram_pt_seq.sv
module sdram_pt_seq
  import sdram_pt_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int ROW_W  = 12,
  parameter int BANK_W = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_four_bank,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic              req_write,
  input  logic              lk_hit,
  output logic              ld_en,
  output logic [BANK_W-1:0] ld_bank,
  output logic [ROW_W-1:0]  ld_row,
  output logic              cmd_valid,
  output cmd_e              cmd_code,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic              stat_valid,
  output logic              stat_hit,
  output logic              stat_err
);

  localparam int HALF = NBANK / 2;

  seq_state_e        state_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic              wr_q;
  logic              accept;
  logic              bad_bank;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign bad_bank  = !cfg_four_bank && (int'(req_bank) >= HALF);

  // the row is loaded on the edge that puts ACTIVATE on the outputs
  assign ld_en   = (state_q == ST_ACT);
  assign ld_bank = bank_q;
  assign ld_row  = row_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      bank_q     <= '0;
      row_q      <= '0;
      wr_q       <= 1'b0;
      cmd_valid  <= 1'b0;
      cmd_code   <= CMD_NOP;
      cmd_bank   <= '0;
      cmd_row    <= '0;
      stat_valid <= 1'b0;
      stat_hit   <= 1'b0;
      stat_err   <= 1'b0;
    end else begin
      cmd_valid  <= 1'b0;
      stat_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            stat_valid <= 1'b1;
            stat_err   <= bad_bank;
            stat_hit   <= !bad_bank && lk_hit;
            bank_q     <= req_bank;
            row_q      <= req_row;
            wr_q       <= req_write;
            cmd_bank   <= req_bank;
            cmd_row    <= req_row;
            if (!bad_bank) begin
              cmd_valid <= 1'b1;
              if (lk_hit) begin
                cmd_code <= req_write ? CMD_WR : CMD_RD;
              end else begin
                cmd_code <= CMD_PRE;
                state_q  <= ST_ACT;
              end
            end
          end
        end
        ST_ACT: begin
          cmd_valid <= 1'b1;
          cmd_code  <= CMD_ACT;
          state_q   <= ST_RW;
        end
        ST_RW: begin
          cmd_valid <= 1'b1;
          cmd_code  <= wr_q ? CMD_WR : CMD_RD;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_pre_then_act_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == CMD_PRE) |=>
      (cmd_valid && cmd_code == CMD_ACT && $stable(cmd_bank)));

  assert_act_then_col_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == CMD_ACT) |=>
      (cmd_valid && (cmd_code == CMD_RD || cmd_code == CMD_WR) && $stable(cmd_bank)));

  assert_hit_single_col_R2: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && stat_hit) |->
      (cmd_valid && (cmd_code == CMD_RD || cmd_code == CMD_WR)));

  assert_miss_starts_pre_R6: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && !stat_hit && !stat_err) |-> (cmd_valid && cmd_code == CMD_PRE));

  assert_err_silent_R7: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && stat_err) |-> (!cmd_valid && req_ready));

  assert_ready_low_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_code == CMD_PRE || cmd_code == CMD_ACT)) |-> !req_ready);

  assert_stat_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    stat_valid |=> !stat_valid || $past(accept));

  assert_stat_excl_R9: assert property (@(posedge clk) disable iff (rst)
    stat_valid |-> !(stat_hit && stat_err));

endmodule

// File: rtl/sdram_page_tracker.sv
module sdram_page_tracker #(
  parameter int NBANK  = 4,
  parameter int ROW_W  = 12,
  parameter int BANK_W = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_four_bank,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic              req_write,
  output logic              cmd_valid,
  output logic [2:0]        cmd_code,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic              stat_valid,
  output logic              stat_hit,
  output logic              stat_err
);

  logic              lk_hit;
  logic              ld_en;
  logic [BANK_W-1:0] ld_bank;
  logic [ROW_W-1:0]  ld_row;
  sdram_pt_pkg::cmd_e code_w;

  sdram_pt_bank_regs #(.NBANK(NBANK), .ROW_W(ROW_W), .BANK_W(BANK_W)) regs_i (
    .clk     (clk),
    .rst     (rst),
    .lk_bank (req_bank),
    .lk_row  (req_row),
    .lk_hit  (lk_hit),
    .ld_en   (ld_en),
    .ld_bank (ld_bank),
    .ld_row  (ld_row)
  );

  sdram_pt_seq #(.NBANK(NBANK), .ROW_W(ROW_W), .BANK_W(BANK_W)) seq_i (
    .clk           (clk),
    .rst           (rst),
    .cfg_four_bank (cfg_four_bank),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_bank      (req_bank),
    .req_row       (req_row),
    .req_write     (req_write),
    .lk_hit        (lk_hit),
    .ld_en         (ld_en),
    .ld_bank       (ld_bank),
    .ld_row        (ld_row),
    .cmd_valid     (cmd_valid),
    .cmd_code      (code_w),
    .cmd_bank      (cmd_bank),
    .cmd_row       (cmd_row),
    .stat_valid    (stat_valid),
    .stat_hit      (stat_hit),
    .stat_err      (stat_err)
  );

  assign cmd_code = code_w;

  // R1: the cycle after reset is released, no command or status is pending
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!cmd_valid && !stat_valid && req_ready));

endmodule

// File: tb/sdram_page_tracker_tb.sv
`timescale 1ns/1ps
module sdram_page_tracker_tb_top;

  localparam int ROW_W  = 12;
  localparam int BANK_W = 2;
  localparam int NV     = 16;
  localparam logic [1:0] HIT = 2'd0, MISS = 2'd1, ERR = 2'd2;

  // vector fields: {four_bank, bank[1:0], row[11:0], write, expect[1:0]}
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 2'd0, 12'h010, 1'b0, MISS},
    {1'b1, 2'd0, 12'h010, 1'b1, HIT },
    {1'b1, 2'd1, 12'h020, 1'b0, MISS},
    {1'b1, 2'd0, 12'h010, 1'b0, HIT },
    {1'b1, 2'd0, 12'h011, 1'b1, MISS},
    {1'b1, 2'd0, 12'h010, 1'b0, MISS},
    {1'b1, 2'd2, 12'h030, 1'b1, MISS},
    {1'b1, 2'd3, 12'hFFF, 1'b0, MISS},
    {1'b1, 2'd3, 12'hFFF, 1'b1, HIT },
    {1'b1, 2'd2, 12'h030, 1'b0, HIT },
    {1'b0, 2'd2, 12'h031, 1'b0, ERR },
    {1'b0, 2'd3, 12'h000, 1'b1, ERR },
    {1'b0, 2'd1, 12'h020, 1'b0, HIT },
    {1'b1, 2'd2, 12'h030, 1'b0, HIT },
    {1'b1, 2'd1, 12'h000, 1'b1, MISS},
    {1'b1, 2'd1, 12'h000, 1'b0, HIT }
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_four_bank = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [BANK_W-1:0] req_bank = '0;
  logic [ROW_W-1:0]  req_row = '0;
  logic              req_write = 1'b0;
  logic              cmd_valid;
  logic [2:0]        cmd_code;
  logic [BANK_W-1:0] cmd_bank;
  logic [ROW_W-1:0]  cmd_row;
  logic              stat_valid, stat_hit, stat_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  sdram_page_tracker #(.NBANK(4), .ROW_W(ROW_W), .BANK_W(BANK_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_four_bank(cfg_four_bank),
    .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
    .req_row(req_row), .req_write(req_write), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .stat_valid(stat_valid), .stat_hit(stat_hit), .stat_err(stat_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic run(input logic four, input logic [1:0] bank, input logic [11:0] row,
                     input logic wr, input logic [1:0] exp);
    logic [2:0] col;
    col = wr ? 3'd4 : 3'd3;
    @(negedge clk);
    cfg_four_bank = four; req_valid = 1'b1;
    req_bank = bank; req_row = row; req_write = wr;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 stat_valid", 32'(stat_valid), 32'd1);
    check("R9 stat_hit", 32'(stat_hit), 32'(exp == HIT));
    check("R7 stat_err", 32'(stat_err), 32'(exp == ERR));
    if (exp == ERR) begin
      check("R7 no command", 32'(cmd_valid), 32'd0);
      check("R7 ready", 32'(req_ready), 32'd1);
      @(negedge clk);
      check("R5 R7 quiet", {cmd_valid, stat_valid}, 32'd0);
    end else if (exp == HIT) begin
      check("R2 R10 col cmd", {cmd_valid, cmd_code, 2'(cmd_bank)}, {1'b1, col, bank});
      @(negedge clk);
      check("R2 single cmd", {cmd_valid, stat_valid}, 32'd0);
    end else begin
      check("R3 R6 pre", {cmd_valid, cmd_code, 2'(cmd_bank)}, {1'b1, 3'd1, bank});
      check("R8 ready pre", 32'(req_ready), 32'd0);
      @(negedge clk);
      check("R3 R4 act", {cmd_valid, cmd_code, 2'(cmd_bank), cmd_row}, {1'b1, 3'd2, bank, row});
      check("R8 ready act", 32'(req_ready), 32'd0);
      check("R9 one pulse", 32'(stat_valid), 32'd0);
      @(negedge clk);
      check("R3 R10 col", {cmd_valid, cmd_code, 2'(cmd_bank)}, {1'b1, col, bank});
      check("R8 ready col", 32'(req_ready), 32'd1);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_up();
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 ready", 32'(req_ready), 32'd1);
    check("R1 idle outputs", {cmd_valid, stat_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][17], VEC[i][16:15], VEC[i][14:3], VEC[i][2], VEC[i][1:0]);
    end

    // R2: back-to-back hits on bank 0 (row 0x010 open from vector 6)
    @(negedge clk);
    cfg_four_bank = 1'b1; req_valid = 1'b1;
    req_bank = 2'd0; req_row = 12'h010; req_write = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_write = 1'b1;
    check("R2 b2b first", {cmd_valid, cmd_code}, {1'b1, 3'd3});
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 b2b second", {cmd_valid, cmd_code, stat_hit}, {1'b1, 3'd4, 1'b1});

    // R1 R6: reset closes all banks, so the same row now misses
    do_reset();
    check("R1 ready after reset", 32'(req_ready), 32'd1);
    run(1'b1, 2'd0, 12'h010, 1'b0, MISS);
    run(1'b1, 2'd3, 12'hFFF, 1'b1, MISS);

    repeat (2) @(negedge clk);
    finish_up();
  end

endmodule